// File: doc/BRIEF.md
# Half-Line Dirty Write-Back Controller

This block holds the per-line state of a data cache that mixes write-through and write-back memory regions. It also writes evicted or cleaned lines back to memory. Every line has a valid flag, a stored physical tag and two dirty flags. One dirty flag covers words 0..3 of the eight-word line and the other covers words 4..7. A store hit updates the line's word. Two region attribute bits, cacheable and bufferable, then decide what else happens. In a write-back region the store marks the matching half dirty. In any other region the store is also sent straight to memory.

A clean command scans one line, or every line in turn. For each dirty half it issues four word writes on the memory port. Clean halves are skipped. The write address is built from the stored physical tag, the set number and the word position, so no address translation takes part. After a line is written back, its dirty flags are cleared. A variant of the command also drops the line's valid flag, which is how an eviction is issued. A one-cycle done strobe marks the end of every command. Tag matching and linefill data lie outside the block: a fill input installs a tag and zeroes the line. Line data lives in a small internal array.

Top module: `halfline_wb_ctrl`

## Requirements
- R1: A store to a valid line with cacheable=1 and bufferable=1 writes the word into the line and sets the dirty flag of its half: words 0..3 map to the lower half and words 4..7 to the upper half. It causes no memory write.
- R2: A store to a valid line under any other combination of the two attribute bits writes the word into the line. In the same cycle it drives mem_we with the store data and the line's address. It sets no dirty flag.
- R3: Every memory address is {stored tag, set, word[2:0], 2'b00}, a byte address.
- R4: Cleaning a line writes only its dirty halves. Each half is four writes of ascending words on consecutive cycles, and the lower half goes first. The first write comes in the second cycle after the command is accepted.
- R5: A line with no dirty flag finishes in one cycle: done is high in the first cycle after acceptance, and there is no memory write.
- R6: Once a line has been written back, both of its dirty flags are clear. A plain clean (cmd_op 2'b00 line, 2'b10 all) leaves the line valid, so later stores still hit it.
- R7: cmd_op bit 0 set (2'b01 line eviction, 2'b11 all) also invalidates. Stores to an invalid line are dropped: they change no data and write no memory.
- R8: A clean of all lines (cmd_op bit 1 set) visits sets in ascending order and ways in ascending order within each set. It raises done once, in the cycle that finishes the last line, and busy drops in the next cycle.
- R9: While busy is high, stores, fills and commands are ignored.
- R10: After reset, every line is invalid and not dirty, busy, done and mem_we are low, and a clean of all lines writes nothing and finishes in NUM_WAYS*NUM_SETS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Install a line: valid, new tag, data zeroed, not dirty |
| fill_way | input | WAY_W | Way of the line to install |
| fill_set | input | SET_W | Set of the line to install |
| fill_ptag | input | TAG_W | Physical tag for the installed line |
| st_en | input | 1 | Store hit request |
| st_way | input | WAY_W | Way hit by the store |
| st_set | input | SET_W | Set hit by the store |
| st_word | input | 3 | Word within the line |
| st_data | input | DATA_W | Store data |
| st_cacheable | input | 1 | Region attribute: cacheable |
| st_bufferable | input | 1 | Region attribute: bufferable |
| cmd_en | input | 1 | Clean command request |
| cmd_op | input | 2 | Bit 1: all lines; bit 0: invalidate as well |
| cmd_way | input | WAY_W | Way for a single-line command |
| cmd_set | input | SET_W | Set for a single-line command |
| busy | output | 1 | A clean command is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
A write-through store appears on the memory port in the same cycle it is presented, with no register in the path. The bench therefore samples mem_we one time unit after driving the store, before the accepting edge. A command is accepted on a rising edge, and the following cycle is the inspection of the first line. Writes occupy the next four cycles per dirty half, and done rises together with the last write of the last line. A command is thus due to finish at cycle 1+4d for each line visited, with the cycles summed over the visited lines. The bench counts cycles from acceptance at every falling edge and compares each write and the done cycle against that count. The bench also checks that busy has dropped one cycle later.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
   localparam int LINE_WORDS = 8;
   localparam int WORD_W     = 3;
   localparam int HALF_WORDS = 4;

   localparam int OP_ALL_BIT = 1;
   localparam int OP_INV_BIT = 0;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_LOOK  = 2'd1,
      WK_WRITE = 2'd2
   } walk_state_e;
endpackage

// File: rtl/hwb_line_store.sv
module hwb_line_store
   import hwb_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int NUM_SETS = 4,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 20,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int LINE_W  = WAY_W + SET_W,
   localparam int LINES   = NUM_WAYS * NUM_SETS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_we,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [TAG_W-1:0]  fill_ptag,
   input  logic              st_we,
   input  logic              st_mark,
   input  logic [WAY_W-1:0]  st_way,
   input  logic [SET_W-1:0]  st_set,
   input  logic [WORD_W-1:0] st_word,
   input  logic [DATA_W-1:0] st_data,
   output logic              st_valid,
   output logic [TAG_W-1:0]  st_ptag,
   input  logic              clr_en,
   input  logic              clr_inv,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [WORD_W-1:0] rd_word,
   output logic [1:0]        rd_dirty,
   output logic [TAG_W-1:0]  rd_ptag,
   output logic [DATA_W-1:0] rd_data
);
   logic              valid_q [LINES];
   logic [1:0]        dirty_q [LINES];
   logic [TAG_W-1:0]  ptag_q  [LINES];
   logic [DATA_W-1:0] data_q  [LINES][LINE_WORDS];

   logic [LINE_W-1:0] fill_idx, st_idx, rd_idx;
   assign fill_idx = {fill_set, fill_way};
   assign st_idx   = {st_set, st_way};
   assign rd_idx   = {rd_set, rd_way};

   for (genvar li = 0; li < LINES; li++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[li] <= 1'b0;
            dirty_q[li] <= 2'b00;
            ptag_q[li]  <= '0;
         end else begin
            if (clr_en && rd_idx == LINE_W'(li)) begin
               dirty_q[li] <= 2'b00;
               if (clr_inv) valid_q[li] <= 1'b0;
            end
            if (st_we && st_mark && st_idx == LINE_W'(li))
               dirty_q[li][st_word[WORD_W-1]] <= 1'b1;
            if (fill_we && fill_idx == LINE_W'(li)) begin
               valid_q[li] <= 1'b1;
               ptag_q[li]  <= fill_ptag;
               dirty_q[li] <= 2'b00;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (st_we) data_q[st_idx][st_word] <= st_data;
      if (fill_we)
         for (int k = 0; k < LINE_WORDS; k++) data_q[fill_idx][k] <= '0;
   end

   assign st_valid = valid_q[st_idx];
   assign st_ptag  = ptag_q[st_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_ptag  = ptag_q[rd_idx];
   assign rd_data  = data_q[rd_idx][rd_word];
endmodule

// File: rtl/hwb_walker.sv
module hwb_walker
   import hwb_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int NUM_SETS = 4,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int LINE_W  = WAY_W + SET_W,
   localparam int LINES   = NUM_WAYS * NUM_SETS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic              cmd_all,
   input  logic              cmd_inv,
   input  logic [WAY_W-1:0]  cmd_way,
   input  logic [SET_W-1:0]  cmd_set,
   input  logic [1:0]        line_dirty,
   output logic              busy,
   output logic [WAY_W-1:0]  cur_way,
   output logic [SET_W-1:0]  cur_set,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_word,
   output logic              clr_en,
   output logic              clr_inv,
   output logic              done
);
   walk_state_e       state_q;
   logic [LINE_W-1:0] idx_q;
   logic              all_q, inv_q, half_q;
   logic [1:0]        cnt_q;
   logic              line_end, last_line, more_half;

   assign cur_way   = idx_q[WAY_W-1:0];
   assign cur_set   = idx_q[LINE_W-1:WAY_W];
   assign last_line = !all_q || (idx_q == LINE_W'(LINES - 1));
   assign more_half = !half_q && line_dirty[1];

   always_comb begin
      line_end = 1'b0;
      unique case (state_q)
         WK_LOOK:  line_end = (line_dirty == 2'b00);
         WK_WRITE: line_end = (cnt_q == 2'd3) && !more_half;
         default:  line_end = 1'b0;
      endcase
   end

   assign busy    = (state_q != WK_IDLE);
   assign wr_en   = (state_q == WK_WRITE);
   assign wr_word = {half_q, cnt_q};
   assign clr_en  = line_end;
   assign clr_inv = inv_q;
   assign done    = line_end && last_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         idx_q   <= '0;
         all_q   <= 1'b0;
         inv_q   <= 1'b0;
         half_q  <= 1'b0;
         cnt_q   <= 2'd0;
      end else begin
         unique case (state_q)
            WK_IDLE: if (cmd_go) begin
               idx_q   <= cmd_all ? '0 : {cmd_set, cmd_way};
               all_q   <= cmd_all;
               inv_q   <= cmd_inv;
               state_q <= WK_LOOK;
            end
            WK_LOOK: begin
               cnt_q <= 2'd0;
               if (line_dirty != 2'b00) begin
                  half_q  <= !line_dirty[0];
                  state_q <= WK_WRITE;
               end else if (last_line) begin
                  state_q <= WK_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            WK_WRITE: begin
               cnt_q <= cnt_q + 2'd1;
               if (cnt_q == 2'd3) begin
                  if (more_half) begin
                     half_q <= 1'b1;
                  end else if (last_line) begin
                     state_q <= WK_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= WK_LOOK;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/halfline_wb_ctrl.sv
module halfline_wb_ctrl
   import hwb_pkg::*;
#(
   parameter int NUM_WAYS     = 4,
   parameter int NUM_SETS     = 4,
   parameter int DATA_W       = 32,
   parameter int TAG_W        = 20,
   parameter bit BYTE_ADDRESS = 1'b1,
   localparam int WAY_W  = $clog2(NUM_WAYS),
   localparam int SET_W  = $clog2(NUM_SETS),
   localparam int OFF_W  = BYTE_ADDRESS ? $clog2(DATA_W / 8) : 0,
   localparam int ADDR_W = TAG_W + SET_W + WORD_W + OFF_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [TAG_W-1:0]  fill_ptag,
   input  logic              st_en,
   input  logic [WAY_W-1:0]  st_way,
   input  logic [SET_W-1:0]  st_set,
   input  logic [WORD_W-1:0] st_word,
   input  logic [DATA_W-1:0] st_data,
   input  logic              st_cacheable,
   input  logic              st_bufferable,
   input  logic              cmd_en,
   input  logic [1:0]        cmd_op,
   input  logic [WAY_W-1:0]  cmd_way,
   input  logic [SET_W-1:0]  cmd_set,
   output logic              busy,
   output logic              done,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_chk_ways
      $error("NUM_WAYS must be a power of two, at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_chk_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_chk_data
      $error("DATA_W must be a whole number of bytes");
   end

   logic              idle, st_valid, st_hit, wb_region, through;
   logic [TAG_W-1:0]  st_ptag, rd_ptag;
   logic [1:0]        rd_dirty;
   logic [DATA_W-1:0] rd_data;
   logic [WAY_W-1:0]  cur_way;
   logic [SET_W-1:0]  cur_set;
   logic              eng_wr, clr_en, clr_inv;
   logic [WORD_W-1:0] eng_word;
   logic [ADDR_W-OFF_W-1:0] eng_waddr, st_waddr, sel_waddr;

   assign idle      = !busy;
   assign wb_region = st_cacheable && st_bufferable;
   assign st_hit    = st_en && idle && st_valid;
   assign through   = st_hit && !wb_region;

   hwb_line_store #(
      .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .DATA_W(DATA_W), .TAG_W(TAG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .fill_we(fill_en && idle), .fill_way(fill_way), .fill_set(fill_set),
      .fill_ptag(fill_ptag),
      .st_we(st_hit), .st_mark(wb_region), .st_way(st_way), .st_set(st_set),
      .st_word(st_word), .st_data(st_data), .st_valid(st_valid), .st_ptag(st_ptag),
      .clr_en(clr_en), .clr_inv(clr_inv),
      .rd_way(cur_way), .rd_set(cur_set), .rd_word(eng_word),
      .rd_dirty(rd_dirty), .rd_ptag(rd_ptag), .rd_data(rd_data)
   );

   hwb_walker #(
      .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .cmd_go(cmd_en && idle), .cmd_all(cmd_op[OP_ALL_BIT]), .cmd_inv(cmd_op[OP_INV_BIT]),
      .cmd_way(cmd_way), .cmd_set(cmd_set), .line_dirty(rd_dirty),
      .busy(busy), .cur_way(cur_way), .cur_set(cur_set),
      .wr_en(eng_wr), .wr_word(eng_word), .clr_en(clr_en), .clr_inv(clr_inv),
      .done(done)
   );

   assign eng_waddr = {rd_ptag, cur_set, eng_word};
   assign st_waddr  = {st_ptag, st_set, st_word};
   assign sel_waddr = eng_wr ? eng_waddr : st_waddr;

   assign mem_we    = eng_wr || through;
   assign mem_wdata = eng_wr ? rd_data : st_data;

   if (OFF_W > 0) begin : g_byte_addr
      assign mem_addr = {sel_waddr, {OFF_W{1'b0}}};
   end else begin : g_word_addr
      assign mem_addr = sel_waddr;
   end
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
   parameter int ADDR_W = 27,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              st_en,
   input logic              st_cacheable,
   input logic              st_bufferable,
   input logic [DATA_W-1:0] st_data,
   input logic              cmd_en,
   input logic              busy,
   input logic              done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   localparam int STEP = 1 << OFF_W;

   p_wb_store_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_en && !busy && st_cacheable && st_bufferable) |-> !mem_we);

   p_wt_store_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mem_we) |-> (st_en && mem_wdata == st_data));

   p_wt_never_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !st_en) |-> !mem_we);

   p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[OFF_W-1:0] == '0));

   p_half_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we && $past(busy && mem_we) && mem_addr[OFF_W +: 2] != 2'b00)
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && !busy) |=> busy);

   p_done_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind halfline_wb_ctrl hwb_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W > 0 ? OFF_W : 1)
) u_hwb_checker (
   .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_cacheable(st_cacheable),
   .st_bufferable(st_bufferable), .st_data(st_data), .cmd_en(cmd_en),
   .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata)
);

// File: tb/tb_halfline_wb_ctrl.sv
module tb_halfline_wb_ctrl;
   localparam int NW = 4;
   localparam int NS = 4;
   localparam int DW = 32;
   localparam int TW = 20;
   localparam int AW = TW + 2 + 3 + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_en = 1'b0;
   logic [1:0]    fill_way = '0, fill_set = '0;
   logic [TW-1:0] fill_ptag = '0;
   logic          st_en = 1'b0;
   logic [1:0]    st_way = '0, st_set = '0;
   logic [2:0]    st_word = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_cacheable = 1'b0, st_bufferable = 1'b0;
   logic          cmd_en = 1'b0;
   logic [1:0]    cmd_op = '0, cmd_way = '0, cmd_set = '0;
   logic          busy, done, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   always #5 clk = !clk;

   halfline_wb_ctrl #(.NUM_WAYS(NW), .NUM_SETS(NS), .DATA_W(DW), .TAG_W(TW)) dut (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_way(fill_way), .fill_set(fill_set), .fill_ptag(fill_ptag),
      .st_en(st_en), .st_way(st_way), .st_set(st_set), .st_word(st_word),
      .st_data(st_data), .st_cacheable(st_cacheable), .st_bufferable(st_bufferable),
      .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_way(cmd_way), .cmd_set(cmd_set),
      .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [DW-1:0] m_data  [NW][NS][8];
   logic [1:0]    m_dirty [NW][NS];
   bit            m_valid [NW][NS];
   logic [TW-1:0] m_tag   [NW][NS];

   logic [AW-1:0] ea [256];
   logic [DW-1:0] ed [256];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk_addr(input logic [TW-1:0] tag, input int s, input int word);
      return {tag, 2'(s), 3'(word), 2'b00};
   endfunction

   task automatic do_fill(input int w, input int s, input logic [TW-1:0] tag);
      @(negedge clk);
      fill_en = 1'b1; fill_way = 2'(w); fill_set = 2'(s); fill_ptag = tag;
      @(negedge clk);
      fill_en = 1'b0;
      m_valid[w][s] = 1'b1; m_tag[w][s] = tag; m_dirty[w][s] = 2'b00;
      for (int k = 0; k < 8; k++) m_data[w][s][k] = '0;
   endtask

   task automatic do_store(input int w, input int s, input int word, input logic [DW-1:0] d,
                           input bit c, input bit b, input string req);
      bit exp_we;
      @(negedge clk);
      st_en = 1'b1; st_way = 2'(w); st_set = 2'(s); st_word = 3'(word);
      st_data = d; st_cacheable = c; st_bufferable = b;
      exp_we = m_valid[w][s] && !(c && b);
      #1;
      chk(mem_we == exp_we, req, "store mem_we", 64'(mem_we), 64'(exp_we));
      if (exp_we) begin
         chk(mem_addr == mk_addr(m_tag[w][s], s, word), req, "store addr",
             64'(mem_addr), 64'(mk_addr(m_tag[w][s], s, word)));
         chk(mem_wdata == d, req, "store data", 64'(mem_wdata), 64'(d));
      end
      @(negedge clk);
      st_en = 1'b0;
      if (m_valid[w][s]) begin
         m_data[w][s][word] = d;
         if (c && b) m_dirty[w][s][word / 4] = 1'b1;
      end
   endtask

   // Runs one command, optionally pokes the inputs in cycle 2, and checks every write and the done cycle.
   task automatic do_cmd(input logic [1:0] op, input int w, input int s, input bit poke,
                         input int pw, input int ps, input string req);
      int n = 0;
      int exp_cyc = 0;
      int got = 0;
      int done_cyc = 0;
      int cyc;
      for (int ss = 0; ss < NS; ss++) begin
         for (int ww = 0; ww < NW; ww++) begin
            if (op[1] || (ss == s && ww == w)) begin
               exp_cyc++;
               for (int h = 0; h < 2; h++) begin
                  if (m_dirty[ww][ss][h]) begin
                     for (int k = 0; k < 4; k++) begin
                        ea[n] = mk_addr(m_tag[ww][ss], ss, h * 4 + k);
                        ed[n] = m_data[ww][ss][h * 4 + k];
                        n++;
                     end
                     exp_cyc += 4;
                  end
               end
            end
         end
      end
      @(negedge clk);
      cmd_en = 1'b1; cmd_op = op; cmd_way = 2'(w); cmd_set = 2'(s);
      @(negedge clk);
      cmd_en = 1'b0;
      cyc = 1;
      while (done_cyc == 0 && cyc < 400) begin
         if (poke && cyc == 2) begin
            st_en = 1'b1; st_way = 2'(pw); st_set = 2'(ps); st_word = 3'd1;
            st_data = 32'hDEAD_0001; st_cacheable = 1'b1; st_bufferable = 1'b0;
            fill_en = 1'b1; fill_way = 2'(pw); fill_set = 2'(ps); fill_ptag = 20'hFFFFF;
            cmd_en = 1'b1; cmd_op = 2'b11;
         end
         #1;
         if (mem_we) begin
            if (got < n) begin
               chk(mem_addr == ea[got], req, "writeback addr", 64'(mem_addr), 64'(ea[got]));
               chk(mem_wdata == ed[got], req, "writeback data", 64'(mem_wdata), 64'(ed[got]));
            end
            got++;
         end
         if (done) done_cyc = cyc;
         @(negedge clk);
         st_en = 1'b0; fill_en = 1'b0; cmd_en = 1'b0;
         if (done_cyc == 0) cyc++;
      end
      chk(got == n, req, "writeback count", 64'(got), 64'(n));
      chk(done_cyc == exp_cyc, req, "done cycle", 64'(done_cyc), 64'(exp_cyc));
      #1;
      chk(busy == 1'b0, "R8", "busy after done", 64'(busy), 64'd0);
      for (int ss = 0; ss < NS; ss++)
         for (int ww = 0; ww < NW; ww++)
            if (op[1] || (ss == s && ww == w)) begin
               m_dirty[ww][ss] = 2'b00;
               if (op[0]) m_valid[ww][ss] = 1'b0;
            end
   endtask

   task automatic t_reset();
      #1;
      chk(busy == 1'b0, "R10", "busy at reset", 64'(busy), 64'd0);
      chk(done == 1'b0, "R10", "done at reset", 64'(done), 64'd0);
      chk(mem_we == 1'b0, "R10", "mem_we at reset", 64'(mem_we), 64'd0);
      do_cmd(2'b10, 0, 0, 1'b0, 0, 0, "R10");
      do_store(2, 2, 3, 32'h1111_2222, 1'b1, 1'b0, "R10");
   endtask

   task automatic t_lower_half();
      do_store(0, 0, 2, 32'hA000_0002, 1'b1, 1'b1, "R1");
      do_cmd(2'b00, 0, 0, 1'b0, 0, 0, "R4");
   endtask

   task automatic t_upper_half();
      do_store(1, 0, 6, 32'hB000_0006, 1'b1, 1'b1, "R1");
      do_cmd(2'b00, 1, 0, 1'b0, 0, 0, "R3");
   endtask

   task automatic t_both_halves();
      do_store(2, 1, 7, 32'hC000_0007, 1'b1, 1'b1, "R1");
      do_store(2, 1, 1, 32'hC000_0001, 1'b1, 1'b1, "R1");
      do_store(2, 1, 4, 32'hC000_0004, 1'b1, 1'b1, "R1");
      do_cmd(2'b00, 2, 1, 1'b0, 0, 0, "R4");
   endtask

   task automatic t_write_through();
      do_store(3, 3, 5, 32'hD000_0005, 1'b1, 1'b0, "R2");
      do_store(3, 3, 0, 32'hD000_0000, 1'b0, 1'b1, "R2");
      do_store(3, 3, 7, 32'hD000_0007, 1'b0, 1'b0, "R2");
      do_cmd(2'b00, 3, 3, 1'b0, 0, 0, "R5");
      do_store(3, 3, 2, 32'hD000_0002, 1'b1, 1'b1, "R2");
      do_cmd(2'b00, 3, 3, 1'b0, 0, 0, "R2");
   endtask

   task automatic t_repeat_clean();
      do_cmd(2'b00, 2, 1, 1'b0, 0, 0, "R6");
      do_store(2, 1, 0, 32'hE000_0000, 1'b1, 1'b1, "R6");
      do_cmd(2'b00, 2, 1, 1'b0, 0, 0, "R6");
   endtask

   task automatic t_evict();
      do_store(0, 2, 3, 32'hF000_0003, 1'b1, 1'b1, "R7");
      do_store(0, 2, 5, 32'hF000_0005, 1'b1, 1'b1, "R7");
      do_cmd(2'b01, 0, 2, 1'b0, 0, 0, "R7");
      do_store(0, 2, 3, 32'hF111_0003, 1'b1, 1'b1, "R7");
      do_store(0, 2, 4, 32'hF111_0004, 1'b1, 1'b0, "R7");
      do_cmd(2'b00, 0, 2, 1'b0, 0, 0, "R7");
   endtask

   task automatic t_busy_ignore();
      do_store(0, 0, 7, 32'h9000_0007, 1'b1, 1'b1, "R9");
      do_cmd(2'b00, 0, 0, 1'b1, 1, 0, "R9");
      do_cmd(2'b00, 1, 0, 1'b0, 0, 0, "R9");
      do_store(1, 0, 0, 32'h9000_1000, 1'b1, 1'b1, "R9");
      do_cmd(2'b00, 1, 0, 1'b0, 0, 0, "R9");
   endtask

   task automatic t_clean_all();
      do_store(0, 0, 0, 32'h8000_0000, 1'b1, 1'b1, "R8");
      do_store(3, 3, 6, 32'h8003_0006, 1'b1, 1'b1, "R8");
      do_store(1, 0, 5, 32'h8001_0005, 1'b1, 1'b1, "R8");
      do_store(1, 0, 2, 32'h8001_0002, 1'b1, 1'b1, "R8");
      do_store(2, 1, 3, 32'h8002_0003, 1'b1, 1'b1, "R8");
      do_cmd(2'b10, 0, 0, 1'b0, 0, 0, "R8");
      do_store(3, 3, 1, 32'h8003_0001, 1'b1, 1'b1, "R6");
      do_cmd(2'b11, 0, 0, 1'b0, 0, 0, "R8");
      do_store(3, 3, 0, 32'h7003_0000, 1'b1, 1'b1, "R7");
      do_cmd(2'b10, 0, 0, 1'b0, 0, 0, "R7");
   endtask

   initial begin
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++) begin
            m_valid[w][s] = 1'b0; m_dirty[w][s] = 2'b00; m_tag[w][s] = '0;
            for (int k = 0; k < 8; k++) m_data[w][s][k] = '0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      do_fill(0, 0, 20'hABCDE);
      do_fill(1, 0, 20'h12345);
      do_fill(2, 1, 20'h0F0F0);
      do_fill(3, 3, 20'h55AA5);
      do_fill(0, 2, 20'h00777);
      t_lower_half();
      t_upper_half();
      t_both_halves();
      t_write_through();
      t_repeat_clean();
      t_evict();
      t_busy_ignore();
      t_clean_all();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule